// File: doc/BRIEF.md
# MSI-X Vector Table and Pending Controller

This block is the device-side engine for message-signalled interrupts with a per-vector table. Software programs each vector's 64-bit message address, 32-bit message data and a per-vector mask through a 32-bit register port. The same port also exposes a read-only bit array of pending vectors. A separate configuration-write port carries the function-level enable and mask-all bits. The device logic raises per-vector interrupt requests and declares which vectors it actually uses through use/unuse requests.

A request for an in-use, unmasked vector becomes a message write on a valid/ready output. A request for a masked vector is remembered as a pending bit. Any write that unmasks such a vector clears its pending bit and sends its message. Several vectors unmasked together are replayed lowest number first, one message per accepted cycle. A configuration write that leaves the function enabled also produces a one-cycle strobe that tells the legacy wire interrupt to deassert.

Top module: `msix_engine`

## Requirements
- R1: After reset the enable and mask-all bits are clear, every table word reads zero except the control word, whose bit 0 (entry mask) reads 1 for every vector, the pending array reads zero, and `msg_valid` is low.
- R2: `cfg_rdata` reports enable in bit 15, mask-all in bit 14, and N-1 in bits 10:0 for N vectors; N must lie in 1..2048, which is checked at elaboration.
- R3: With `reg_addr` top bit 0, entry v sits at byte offset 16*v. Word 0 is address bits 31:0, word 4 is address bits 63:32, word 8 is data, and word 12 is control, with bit 0 the mask and the other bits reading 0. A write or read takes effect only with `reg_be` = 4'hF and `reg_addr[1:0]` = 0; otherwise the write is ignored and the read returns 0.
- R4: With `reg_addr` top bit 1, word w of the pending array returns in bit b the pending state of vector 32*w+b. That places vector v in byte v/8 at bit v mod 8. Writes to the pending array are ignored.
- R5: The function is masked when enable is 0 or mask-all is 1. A vector is masked when the function is masked or its own entry mask bit is 1.
- R6: An interrupt request for a vector number of N or more, or for a vector whose use count is zero, has no effect.
- R7: An interrupt request for an in-use, masked vector sets that vector's pending bit and sends nothing.
- R8: An interrupt request for an in-use, unmasked vector sends one message carrying that entry's address and data.
- R9: When a table write, a mask-all change or an enable change turns a masked vector into an unmasked one while its pending bit is set, the pending bit clears and the vector's message is sent.
- R10: An interrupt request is judged against the mask state that results from a table or configuration write in the same cycle.
- R11: Each vector has a use count. Use increments it (saturating), and unuse decrements it. Unuse at count zero, or on a vector number of N or more, is ignored. A decrement to zero clears that vector's pending bit.
- R12: `intx_deassert` pulses for exactly the one cycle after a configuration write with `cfg_enable` = 1.
- R13: Messages waiting together leave in ascending vector order, one per cycle with `msg_ready` high. `msg_valid` stays high while `msg_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte enables; must be all ones |
| reg_addr | input | ADDR_W | Byte address; top bit selects the pending array |
| reg_wdata | input | 32 | Write data, little-endian |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cfg_wr | input | 1 | Configuration control write strobe |
| cfg_enable | input | 1 | New enable value |
| cfg_mask_all | input | 1 | New mask-all value |
| cfg_rdata | output | 16 | Message-control word |
| irq_req | input | 1 | Interrupt request |
| irq_vec | input | 11 | Requested vector |
| use_req | input | 1 | Use-count increment |
| use_vec | input | 11 | Vector for use |
| unuse_req | input | 1 | Use-count decrement |
| unuse_vec | input | 11 | Vector for unuse |
| msg_valid | output | 1 | Message write valid |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| intx_deassert | output | 1 | Legacy interrupt deassert strobe |

## Verification
An interrupt request and a write that changes the mask state can land in the same cycle. Only the order between them decides whether the request becomes a pending bit or an immediate message. The bench drives a mask-all set together with a request, a mask-all clear together with a request on a second vector, and an entry-mask write together with a request on that same entry. Each outcome is judged by reading the pending array and by the order and content of the messages that follow, with the lower vector expected first.

// File: rtl/msix_pkg.sv
package msix_pkg;

   // widest vector number carried on the request ports
   localparam int unsigned VEC_PORT_W = 11;
   localparam int unsigned MAX_VECS   = 2048;

   // word select inside one 16-byte table entry
   typedef enum logic [1:0] {
      W_ADDR_LO = 2'd0,
      W_ADDR_HI = 2'd1,
      W_DATA    = 2'd2,
      W_CTRL    = 2'd3
   } entry_word_e;

   typedef struct packed {
      logic [63:0] addr;
      logic [31:0] data;
   } msix_msg_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
   import msix_pkg::*;
#(
   parameter int unsigned NUM_VEC = 8,
   parameter int unsigned VIDX_W  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [VIDX_W-1:0]    wr_vec,
   input  entry_word_e          wr_word,
   input  logic [31:0]          wr_data,
   input  logic [VIDX_W-1:0]    rd_vec,
   input  entry_word_e          rd_word,
   output logic [31:0]          rd_data,
   input  logic [VIDX_W-1:0]    msg_vec,
   output msix_msg_t            msg,
   output logic [NUM_VEC-1:0]   mask_q,
   output logic [NUM_VEC-1:0]   mask_d
);

   logic [31:0] addr_lo [NUM_VEC];
   logic [31:0] addr_hi [NUM_VEC];
   logic [31:0] mdata   [NUM_VEC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int v = 0; v < NUM_VEC; v++) begin
            addr_lo[v] <= '0;
            addr_hi[v] <= '0;
            mdata[v]   <= '0;
         end
         mask_q <= '1;
      end else if (wr_en) begin
         case (wr_word)
            W_ADDR_LO: addr_lo[wr_vec] <= wr_data;
            W_ADDR_HI: addr_hi[wr_vec] <= wr_data;
            W_DATA:    mdata[wr_vec]   <= wr_data;
            default:   mask_q[wr_vec]  <= wr_data[0];
         endcase
      end
   end

   // mask bits as they will be after this cycle's write
   always_comb begin
      mask_d = mask_q;
      if (wr_en && (wr_word == W_CTRL)) mask_d[wr_vec] = wr_data[0];
   end

   always_comb begin
      case (rd_word)
         W_ADDR_LO: rd_data = addr_lo[rd_vec];
         W_ADDR_HI: rd_data = addr_hi[rd_vec];
         W_DATA:    rd_data = mdata[rd_vec];
         default:   rd_data = {31'd0, mask_q[rd_vec]};
      endcase
   end

   assign msg.addr = {addr_hi[msg_vec], addr_lo[msg_vec]};
   assign msg.data = mdata[msg_vec];

endmodule

// File: rtl/msix_use_track.sv
module msix_use_track #(
   parameter int unsigned NUM_VEC = 8,
   parameter int unsigned VIDX_W  = 3,
   parameter int unsigned CNT_W   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 use_en,
   input  logic [VIDX_W-1:0]    use_vec,
   input  logic                 unuse_en,
   input  logic [VIDX_W-1:0]    unuse_vec,
   output logic [NUM_VEC-1:0]   in_use,
   output logic [NUM_VEC-1:0]   drop_clr
);

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_cnt
      logic [CNT_W-1:0] cnt_q;
      logic             inc;
      logic             dec;

      assign inc = use_en   && (use_vec   == VIDX_W'(v)) && (cnt_q != '1);
      assign dec = unuse_en && (unuse_vec == VIDX_W'(v)) && (cnt_q != '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt_q <= '0;
         else if (inc && !dec) cnt_q <= cnt_q + CNT_W'(1);
         else if (dec && !inc) cnt_q <= cnt_q - CNT_W'(1);
      end

      assign in_use[v]   = (cnt_q != '0);
      assign drop_clr[v] = dec && !inc && (cnt_q == CNT_W'(1));
   end

endmodule

// File: rtl/msix_pend_fire.sv
module msix_pend_fire #(
   parameter int unsigned NUM_VEC = 8,
   parameter int unsigned VIDX_W  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_VEC-1:0]   masked_q,
   input  logic [NUM_VEC-1:0]   masked_d,
   input  logic [NUM_VEC-1:0]   irq_hit,
   input  logic [NUM_VEC-1:0]   unuse_clr,
   input  logic                 take,
   output logic [NUM_VEC-1:0]   pend_q,
   output logic                 any_fire,
   output logic [VIDX_W-1:0]    sel_vec
);

   logic [NUM_VEC-1:0] fire_q;
   logic [NUM_VEC-1:0] fire_d;
   logic [NUM_VEC-1:0] pend_d;
   logic [NUM_VEC-1:0] unmask_edge;
   logic [NUM_VEC-1:0] fire_set;
   logic [NUM_VEC-1:0] take_oh;

   // requests are judged against the post-write mask state
   assign unmask_edge = masked_q & ~masked_d;
   assign fire_set    = (irq_hit & ~masked_d) | (unmask_edge & pend_q & ~unuse_clr);
   assign pend_d      = (pend_q | (irq_hit & masked_d)) & ~unmask_edge & ~unuse_clr;

   // lowest numbered queued vector goes first
   always_comb begin
      sel_vec = '0;
      for (int v = NUM_VEC - 1; v >= 0; v--) begin
         if (fire_q[v]) sel_vec = VIDX_W'(v);
      end
   end

   always_comb begin
      take_oh = '0;
      if (take) take_oh[sel_vec] = 1'b1;
   end

   assign fire_d   = (fire_q & ~take_oh) | fire_set;
   assign any_fire = |fire_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         fire_q <= '0;
      end else begin
         pend_q <= pend_d;
         fire_q <= fire_d;
      end
   end

endmodule

// File: rtl/msix_engine.sv
module msix_engine
   import msix_pkg::*;
#(
   parameter int unsigned NUM_VEC = 8,
   parameter int unsigned CNT_W   = 4,
   localparam int unsigned VIDX_W = idx_width(NUM_VEC),
   localparam int unsigned TBL_AW = VIDX_W + 4,
   localparam int unsigned ADDR_W = TBL_AW + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [3:0]             reg_be,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   input  logic                   cfg_wr,
   input  logic                   cfg_enable,
   input  logic                   cfg_mask_all,
   output logic [15:0]            cfg_rdata,
   input  logic                   irq_req,
   input  logic [VEC_PORT_W-1:0]  irq_vec,
   input  logic                   use_req,
   input  logic [VEC_PORT_W-1:0]  use_vec,
   input  logic                   unuse_req,
   input  logic [VEC_PORT_W-1:0]  unuse_vec,
   output logic                   msg_valid,
   input  logic                   msg_ready,
   output logic [63:0]            msg_addr,
   output logic [31:0]            msg_data,
   output logic                   intx_deassert
);

   localparam int unsigned PBA_WORDS = (NUM_VEC + 31) / 32;
   localparam int unsigned PW_IDX_W  = TBL_AW - 2;

   // R2: vector count range
   if (NUM_VEC < 1 || NUM_VEC > MAX_VECS) begin : g_bad_num_vec
      $error("msix_engine: NUM_VEC out of range");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("msix_engine: CNT_W must be positive");
   end

   // ---------------- register decode ----------------
   logic              acc_ok;
   logic              in_pba;
   logic [VIDX_W-1:0] a_vec;
   logic              a_vec_ok;
   entry_word_e       a_word;
   logic              tbl_wr;

   assign acc_ok   = (reg_be == 4'hF) && (reg_addr[1:0] == 2'b00);
   assign in_pba   = reg_addr[ADDR_W-1];
   assign a_vec    = reg_addr[TBL_AW-1:4];
   assign a_vec_ok = (32'(a_vec) < NUM_VEC);
   assign a_word   = entry_word_e'(reg_addr[3:2]);
   assign tbl_wr   = reg_wr && acc_ok && !in_pba && a_vec_ok;

   // ---------------- function control ----------------
   logic en_q, mall_q, en_d, mall_d;
   logic fmask_q, fmask_d;
   logic intx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mall_q <= 1'b0;
         intx_q <= 1'b0;
      end else begin
         intx_q <= cfg_wr && cfg_enable;
         if (cfg_wr) begin
            en_q   <= cfg_enable;
            mall_q <= cfg_mask_all;
         end
      end
   end

   assign en_d    = cfg_wr ? cfg_enable   : en_q;
   assign mall_d  = cfg_wr ? cfg_mask_all : mall_q;
   assign fmask_q = !en_q || mall_q;
   assign fmask_d = !en_d || mall_d;

   assign cfg_rdata     = {en_q, mall_q, 3'b000, 11'(NUM_VEC - 1)};
   assign intx_deassert = intx_q;

   // ---------------- vector table ----------------
   logic [NUM_VEC-1:0] tbl_mask_q, tbl_mask_d;
   logic [NUM_VEC-1:0] masked_q, masked_d;
   logic [31:0]        tbl_rd;
   logic [VIDX_W-1:0]  sel_vec;
   msix_msg_t          sel_msg;

   msix_vec_table #(.NUM_VEC(NUM_VEC), .VIDX_W(VIDX_W)) i_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr),
      .wr_vec  (a_vec),
      .wr_word (a_word),
      .wr_data (reg_wdata),
      .rd_vec  (a_vec),
      .rd_word (a_word),
      .rd_data (tbl_rd),
      .msg_vec (sel_vec),
      .msg     (sel_msg),
      .mask_q  (tbl_mask_q),
      .mask_d  (tbl_mask_d)
   );

   assign masked_q = {NUM_VEC{fmask_q}} | tbl_mask_q;
   assign masked_d = {NUM_VEC{fmask_d}} | tbl_mask_d;

   // ---------------- use tracking ----------------
   logic               use_ok, unuse_ok, irq_ok;
   logic [NUM_VEC-1:0] in_use;
   logic [NUM_VEC-1:0] drop_clr;

   assign use_ok   = use_req   && (32'(use_vec)   < NUM_VEC);
   assign unuse_ok = unuse_req && (32'(unuse_vec) < NUM_VEC);
   assign irq_ok   = irq_req   && (32'(irq_vec)   < NUM_VEC);

   msix_use_track #(.NUM_VEC(NUM_VEC), .VIDX_W(VIDX_W), .CNT_W(CNT_W)) i_use (
      .clk       (clk),
      .rst_n     (rst_n),
      .use_en    (use_ok),
      .use_vec   (use_vec[VIDX_W-1:0]),
      .unuse_en  (unuse_ok),
      .unuse_vec (unuse_vec[VIDX_W-1:0]),
      .in_use    (in_use),
      .drop_clr  (drop_clr)
   );

   // ---------------- request steering ----------------
   logic [NUM_VEC-1:0] irq_hit;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_irq
      assign irq_hit[v] = irq_ok && (irq_vec[VIDX_W-1:0] == VIDX_W'(v)) && in_use[v];
   end

   // ---------------- pending and message queue ----------------
   logic [NUM_VEC-1:0] pend_q;
   logic               any_fire;
   logic               take;

   assign take = any_fire && msg_ready;

   msix_pend_fire #(.NUM_VEC(NUM_VEC), .VIDX_W(VIDX_W)) i_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .masked_q  (masked_q),
      .masked_d  (masked_d),
      .irq_hit   (irq_hit),
      .unuse_clr (drop_clr),
      .take      (take),
      .pend_q    (pend_q),
      .any_fire  (any_fire),
      .sel_vec   (sel_vec)
   );

   assign msg_valid = any_fire;
   assign msg_addr  = sel_msg.addr;
   assign msg_data  = sel_msg.data;

   // ---------------- pending array read ----------------
   logic [PBA_WORDS*32-1:0] pend_pad;
   logic [PW_IDX_W-1:0]     pw_idx;
   logic [31:0]             pba_word;

   always_comb begin
      pend_pad                = '0;
      pend_pad[NUM_VEC-1:0]   = pend_q;
   end

   assign pw_idx = reg_addr[TBL_AW-1:2];

   if (PBA_WORDS == 1) begin : g_pba_one
      assign pba_word = (pw_idx == '0) ? pend_pad[31:0] : 32'd0;
   end else begin : g_pba_multi
      assign pba_word = (32'(pw_idx) < PBA_WORDS) ? pend_pad[{pw_idx, 5'd0} +: 32] : 32'd0;
   end

   always_comb begin
      reg_rdata = 32'd0;
      if (acc_ok) begin
         if (in_pba)        reg_rdata = pba_word;
         else if (a_vec_ok) reg_rdata = tbl_rd;
      end
   end

endmodule

// File: rtl/msix_chk.sv
module msix_chk #(
   parameter int unsigned NUM_VEC = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_wr,
   input logic               cfg_enable,
   input logic               intx_deassert,
   input logic               msg_valid,
   input logic               msg_ready,
   input logic [NUM_VEC-1:0] pend_q,
   input logic [NUM_VEC-1:0] masked_q,
   input logic [NUM_VEC-1:0] in_use
);

   // R12
   intx_after_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intx_deassert |-> $past(cfg_wr && cfg_enable));

   // R9
   pend_only_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~masked_q) == '0);

   // R13
   valid_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> msg_valid);

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      // R6
      pend_needs_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_q[v]) |-> $past(in_use[v]));
   end

endmodule

bind msix_engine msix_chk #(.NUM_VEC(NUM_VEC)) i_msix_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_wr        (cfg_wr),
   .cfg_enable    (cfg_enable),
   .intx_deassert (intx_deassert),
   .msg_valid     (msg_valid),
   .msg_ready     (msg_ready),
   .pend_q        (pend_q),
   .masked_q      (masked_q),
   .in_use        (in_use)
);

// File: tb/test_msix_engine.sv
module test_msix_engine;

   localparam int CLK_PERIOD = 10;
   localparam int NV         = 12;
   localparam int AW         = 9;
   localparam logic [AW-1:0] PBA = 9'h100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_be = 4'hF;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cfg_wr = 1'b0, cfg_enable = 1'b0, cfg_mask_all = 1'b0;
   logic [15:0] cfg_rdata;
   logic        irq_req = 1'b0, use_req = 1'b0, unuse_req = 1'b0;
   logic [10:0] irq_vec = '0, use_vec = '0, unuse_vec = '0;
   logic        msg_valid, msg_ready = 1'b1;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;
   logic        intx_deassert;

   int checks = 0;
   int errors = 0;
   logic [31:0] mlog [64];
   int mcount = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msix_engine #(.NUM_VEC(NV)) i_msix_engine (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_be(reg_be), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cfg_wr(cfg_wr), .cfg_enable(cfg_enable), .cfg_mask_all(cfg_mask_all),
      .cfg_rdata(cfg_rdata),
      .irq_req(irq_req), .irq_vec(irq_vec),
      .use_req(use_req), .use_vec(use_vec),
      .unuse_req(unuse_req), .unuse_vec(unuse_vec),
      .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_addr(msg_addr), .msg_data(msg_data),
      .intx_deassert(intx_deassert)
   );

   // accepted messages, sampled mid-cycle before the accepting edge
   always @(negedge clk) begin
      if (rst_n && msg_valid && msg_ready && mcount < 64) begin
         mlog[mcount] = msg_data;
         mcount++;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
      tick();
      reg_wr = 1'b0; reg_be = 4'hF;
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      reg_addr = a; reg_be = 4'hF;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic cfg(input logic en, input logic mall);
      cfg_wr = 1'b1; cfg_enable = en; cfg_mask_all = mall;
      tick();
      cfg_wr = 1'b0;
   endtask

   task automatic irq(input int v);
      irq_req = 1'b1; irq_vec = 11'(v);
      tick();
      irq_req = 1'b0;
   endtask

   task automatic use_v(input int v);
      use_req = 1'b1; use_vec = 11'(v);
      tick();
      use_req = 1'b0;
   endtask

   task automatic unuse_v(input int v);
      unuse_req = 1'b1; unuse_vec = 11'(v);
      tick();
      unuse_req = 1'b0;
   endtask

   function automatic logic [AW-1:0] ent(input int v, input int word);
      return AW'(v * 16 + word * 4);
   endfunction

   task automatic t_reset();
      check("R1 msg_valid", msg_valid, 0);
      check("R2 cfg_rdata", cfg_rdata, 16'h000B);
      rd_chk("R1 ctrl mask v3", ent(3, 3), 32'h1);
      rd_chk("R1 data v0", ent(0, 2), 32'h0);
      rd_chk("R1 pending", PBA, 32'h0);
   endtask

   task automatic t_program();
      for (int v = 0; v < NV; v++) begin
         wr(ent(v, 0), 32'hFEE0_0000 + 32'(v * 4), 4'hF);
         wr(ent(v, 1), 32'h0000_0001, 4'hF);
         wr(ent(v, 2), 32'h100 + 32'(v), 4'hF);
         if (v != 9) wr(ent(v, 3), 32'h0, 4'hF);
      end
      rd_chk("R3 data v11", ent(11, 2), 32'h10B);
      rd_chk("R3 addr hi v5", ent(5, 1), 32'h1);
      wr(ent(11, 2), 32'hDEAD, 4'h7);
      rd_chk("R3 partial write ignored", ent(11, 2), 32'h10B);
      wr(ent(11, 2) + 9'd1, 32'hBEEF, 4'hF);
      rd_chk("R3 misaligned write ignored", ent(11, 2), 32'h10B);
      rd_chk("R3 ctrl v0 unmasked", ent(0, 3), 32'h0);
      rd_chk("R3 ctrl v9 masked", ent(9, 3), 32'h1);
   endtask

   task automatic t_func_mask();
      use_v(2);
      irq(2);
      rd_chk("R7 pending v2 while disabled", PBA, 32'h4);
      check("R5 no message while disabled", msg_valid, 0);
      check("R5 no message logged", mcount, 0);
   endtask

   task automatic t_enable();
      cfg(1'b1, 1'b0);
      check("R12 intx pulse", intx_deassert, 1);
      check("R9 replay valid on enable", msg_valid, 1);
      check("R8 replay data", msg_data, 32'h102);
      check("R8 replay addr", msg_addr, 64'h0000_0001_FEE0_0008);
      rd_chk("R9 pending cleared", PBA, 32'h0);
      tick();
      check("R12 intx one cycle", intx_deassert, 0);
      check("R13 message taken", msg_valid, 0);
      check("R8 one message", mcount, 1);
      check("R2 cfg enabled", cfg_rdata, 16'h800B);
   endtask

   task automatic t_vec_mask();
      use_v(9);
      irq(9);
      rd_chk("R4 pending v9 byte1 bit1", PBA, 32'h200);
      wr(PBA, 32'h0, 4'hF);
      rd_chk("R4 pending write ignored", PBA, 32'h200);
      wr(ent(9, 3), 32'h0, 4'hF);
      check("R9 table unmask fires", msg_valid, 1);
      check("R9 table unmask data", msg_data, 32'h109);
      rd_chk("R9 pending v9 cleared", PBA, 32'h0);
      tick();
      check("R8 direct count", mcount, 2);
      irq(2);
      check("R8 direct message", msg_data, 32'h102);
      tick();
      check("R8 direct logged", mcount, 3);
   endtask

   task automatic t_drop();
      irq(5);
      irq(13);
      irq(2047);
      tick();
      check("R6 no message for dropped", msg_valid, 0);
      check("R6 none logged", mcount, 3);
      rd_chk("R6 no pending", PBA, 32'h0);
   endtask

   task automatic t_order();
      use_v(1); use_v(4); use_v(7);
      cfg(1'b1, 1'b1);
      irq(7); irq(4); irq(1);
      rd_chk("R5 mask-all pends", PBA, 32'h92);
      msg_ready = 1'b0;
      cfg(1'b1, 1'b0);
      check("R13 first is lowest", msg_data, 32'h101);
      tick();
      check("R13 held under backpressure", msg_valid, 1);
      check("R13 data held", msg_data, 32'h101);
      msg_ready = 1'b1;
      tick();
      check("R13 second", msg_data, 32'h104);
      tick();
      check("R13 third", msg_data, 32'h107);
      tick();
      check("R13 drained", msg_valid, 0);
      check("R13 count", mcount, 6);
      check("R13 log0", mlog[3], 32'h101);
      check("R13 log1", mlog[4], 32'h104);
      check("R13 log2", mlog[5], 32'h107);
   endtask

   task automatic t_concurrent();
      cfg_wr = 1'b1; cfg_enable = 1'b1; cfg_mask_all = 1'b1;
      irq_req = 1'b1; irq_vec = 11'd4;
      tick();
      cfg_wr = 1'b0; irq_req = 1'b0;
      check("R10 mask and irq same cycle no msg", msg_valid, 0);
      rd_chk("R10 mask and irq same cycle pends", PBA, 32'h10);
      cfg_wr = 1'b1; cfg_enable = 1'b1; cfg_mask_all = 1'b0;
      irq_req = 1'b1; irq_vec = 11'd1;
      tick();
      cfg_wr = 1'b0; irq_req = 1'b0;
      check("R10 unmask and irq first", msg_data, 32'h101);
      rd_chk("R10 pending cleared", PBA, 32'h0);
      tick();
      check("R10 replay second", msg_data, 32'h104);
      tick();
      check("R10 drained", msg_valid, 0);
      reg_wr = 1'b1; reg_addr = ent(7, 3); reg_wdata = 32'h1; reg_be = 4'hF;
      irq_req = 1'b1; irq_vec = 11'd7;
      tick();
      reg_wr = 1'b0; irq_req = 1'b0;
      check("R10 entry mask with irq no msg", msg_valid, 0);
      rd_chk("R10 entry mask with irq pends", PBA, 32'h80);
      wr(ent(7, 3), 32'h0, 4'hF);
      check("R9 entry unmask replays", msg_data, 32'h107);
      tick();
      check("R10 total", mcount, 9);
   endtask

   task automatic t_use();
      cfg(1'b1, 1'b1);
      use_v(3); use_v(3);
      irq(3);
      rd_chk("R11 pending v3", PBA, 32'h8);
      unuse_v(3);
      rd_chk("R11 still pending after one unuse", PBA, 32'h8);
      unuse_v(3);
      rd_chk("R11 cleared at zero", PBA, 32'h0);
      cfg(1'b1, 1'b0);
      tick();
      check("R11 no replay after clear", mcount, 9);
      unuse_v(6);
      use_v(6);
      unuse_v(6);
      irq(6);
      tick();
      check("R11 unuse at zero ignored", mcount, 9);
      check("R11 no message v6", msg_valid, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      t_program();
      t_func_mask();
      t_enable();
      t_vec_mask();
      t_drop();
      t_order();
      t_concurrent();
      t_use();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule